// File: doc/BRIEF.md
# Three-Level Virtual Address Translation Walker

This block turns one 39-bit virtual address into a physical page base. It walks a three-level radix page table held in memory. A request gives the virtual page bits and three flags: supervisor, store and fetch. The walker then reads up to three 8-byte table entries through a single-outstanding memory port, starting from the root table base. At the leaf it checks the access rights. It writes the entry back with its referenced bit set, and also its dirty bit when the access is a store. It returns either a page base or a fault.

A leaf found at the top level maps 1 GiB and a leaf found at the middle level maps 2 MiB. For these large mappings, the virtual page number bits below that level are merged by OR into the physical page number. The block checks every table entry address against the size of memory, and it checks the final page base the same way. The block holds no translation cache.

Top module: `sv39_walker`

## Requirements
- R1: If bits 63 down to 38 of the virtual address are not all equal, the walk ends with a fault and no memory request is made. The done pulse comes one cycle after acceptance.
- R2: Entry addresses are base + index*8. The first base is root_base. The index is VA[38:30], then VA[29:21], then VA[20:12]. Reads are made in that order.
- R3: An entry address at or above mem_size ends the walk with a fault, without a memory request for that entry.
- R4: An entry with bit 0 (valid) clear ends the walk with a fault.
- R5: An entry whose type field (bits 4:1) is 0 points to the next table, whose base is (entry >> 10) << 12. Such an entry at the last level ends the walk with a fault.
- R6: A non-zero type field marks a leaf. Type bit 0 allows loads, bit 1 stores and bit 2 fetches; fetch takes priority over store, and an access with neither is a load. Type bit 3 set marks a user page, which a supervisor access may not use, and clear marks a supervisor page, which a user access may not use. A failed check faults with no write-back.
- R7: A leaf that passes R6 is written back to its own address. The written value is the entry with bit 5 set, and with bit 6 also set for a store; all other bits are unchanged.
- R8: The page base is (PPN | (VPN & low mask)) << 12. PPN is the entry >> 10 and VPN is VA >> 12. The low mask is 18 bits for a top-level leaf, 9 bits for a middle-level leaf and none for a last-level leaf.
- R9: A page base at or above mem_size reports a fault after the write-back of R7 has completed.
- R10: req_ready is high only while idle. A memory request holds its address, direction and data until accepted. done is a one-cycle pulse, and done_base is 0 when done_fault is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va_hi | input | 52 | Virtual address bits 63:12 |
| req_supervisor | input | 1 | Access made in supervisor mode |
| req_store | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| root_base | input | 64 | Physical base of the top-level table |
| mem_size | input | 64 | Bytes of physical memory |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 64 | Request byte address |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_rdata | input | 64 | Read data |
| done | output | 1 | Walk finished (one cycle) |
| done_fault | output | 1 | Walk failed |
| done_base | output | 64 | Physical page base |

## Verification
The bench aims at the edges of each decision:
- Virtual addresses with a single flipped upper bit, which a walker that checks only bit 63 would translate.
- A root placed half a page below mem_size, so that only high indices fall out of range; an off-by-one compare would read one entry too many.
- Large-page leaves whose merged VPN bits push the base past mem_size. A walker that masks the wrong number of bits, or that checks the base before the write-back, shows a wrong base or a missing write.
- Leaves that are both writable and readable, requested with store and fetch together. A wrong priority would set the dirty bit or grant the access.

// File: rtl/sv39_walk_pkg.sv
package sv39_walk_pkg;
    // Entry field positions
    localparam int PTE_V_BIT     = 0;
    localparam int PTE_TYPE_LSB  = 1;
    localparam int PTE_TYPE_W    = 4;
    localparam int PTE_REF_BIT   = 5;
    localparam int PTE_DIRTY_BIT = 6;
    localparam int PTE_PPN_LSB   = 10;
    // Leaf type bit meanings
    localparam int TYPE_R_BIT = 0;
    localparam int TYPE_W_BIT = 1;
    localparam int TYPE_X_BIT = 2;
    localparam int TYPE_U_BIT = 3;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_RD_REQ,
        WS_RD_RSP,
        WS_WR_REQ,
        WS_WR_RSP
    } walk_state_e;

    typedef enum logic [1:0] {
        ACC_LOAD,
        ACC_STORE,
        ACC_FETCH
    } access_e;
endpackage

// File: rtl/sv39_walk_index.sv
module sv39_walk_index #(
    parameter int XLEN     = 64,
    parameter int IDX_W    = 9,
    parameter int LEVELS   = 3,
    parameter int LVL_W    = 2,
    parameter int PTE_LOG2 = 3,
    localparam int VPN_W   = IDX_W * LEVELS
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] level,
    input  logic [XLEN-1:0]  base,
    input  logic [XLEN-1:0]  mem_size,
    output logic [XLEN-1:0]  pte_addr,
    output logic             in_range
);
    logic [IDX_W-1:0] slice_by_lvl [LEVELS];
    logic [IDX_W-1:0] idx;

    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice_by_lvl[g] = vpn[g*IDX_W +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (level == LVL_W'(l)) idx = slice_by_lvl[l];
        end
    end

    assign pte_addr = base + (XLEN'(idx) << PTE_LOG2);
    assign in_range = pte_addr < mem_size;
endmodule

// File: rtl/sv39_walk_leaf.sv
module sv39_walk_leaf
    import sv39_walk_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int PG_SHIFT = 12,
    parameter int IDX_W    = 9,
    parameter int LEVELS   = 3,
    parameter int LVL_W    = 2,
    localparam int VPN_W   = IDX_W * LEVELS
) (
    input  logic [XLEN-1:0]  pte,
    input  access_e          kind,
    input  logic             sup,
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] level,
    input  logic [XLEN-1:0]  mem_size,
    output logic             valid,
    output logic             is_table,
    output logic             perm_ok,
    output logic [XLEN-1:0]  next_base,
    output logic [XLEN-1:0]  page_base,
    output logic             base_ok,
    output logic [XLEN-1:0]  wb_data
);
    logic [PTE_TYPE_W-1:0] ptype;
    logic [XLEN-1:0]       ppn;
    logic [XLEN-1:0]       mask_by_lvl [LEVELS];
    logic [XLEN-1:0]       low_mask;
    logic                  right_ok;

    assign ptype    = pte[PTE_TYPE_LSB +: PTE_TYPE_W];
    assign valid    = pte[PTE_V_BIT];
    assign is_table = (ptype == '0);
    assign ppn      = pte >> PTE_PPN_LSB;

    always_comb begin
        unique case (kind)
            ACC_FETCH: right_ok = ptype[TYPE_X_BIT];
            ACC_STORE: right_ok = ptype[TYPE_W_BIT];
            default:   right_ok = ptype[TYPE_R_BIT];
        endcase
    end
    assign perm_ok = right_ok && (ptype[TYPE_U_BIT] != sup);

    for (genvar g = 0; g < LEVELS; g++) begin : g_mask
        assign mask_by_lvl[g] = (XLEN'(1) << (g*IDX_W)) - XLEN'(1);
    end

    always_comb begin
        low_mask = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (level == LVL_W'(l)) low_mask = mask_by_lvl[l];
        end
    end

    assign next_base = ppn << PG_SHIFT;
    assign page_base = (ppn | (XLEN'(vpn) & low_mask)) << PG_SHIFT;
    assign base_ok   = page_base < mem_size;

    always_comb begin
        wb_data = pte;
        wb_data[PTE_REF_BIT] = 1'b1;
        if (kind == ACC_STORE) wb_data[PTE_DIRTY_BIT] = 1'b1;
    end
endmodule

// File: rtl/sv39_walker.sv
module sv39_walker
    import sv39_walk_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int VA_BITS   = 39,
    parameter int PG_SHIFT  = 12,
    parameter int IDX_W     = 9,
    parameter int LEVELS    = 3,
    parameter int PTE_BYTES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [XLEN-1:PG_SHIFT] req_va_hi,
    input  logic                   req_supervisor,
    input  logic                   req_store,
    input  logic                   req_fetch,
    input  logic [XLEN-1:0]        root_base,
    input  logic [XLEN-1:0]        mem_size,
    output logic                   mem_req_valid,
    input  logic                   mem_req_ready,
    output logic                   mem_req_write,
    output logic [XLEN-1:0]        mem_req_addr,
    output logic [XLEN-1:0]        mem_req_wdata,
    input  logic                   mem_rsp_valid,
    input  logic [XLEN-1:0]        mem_rsp_rdata,
    output logic                   done,
    output logic                   done_fault,
    output logic [XLEN-1:0]        done_base
);
    localparam int VPN_W    = IDX_W * LEVELS;
    localparam int LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int PTE_LOG2 = $clog2(PTE_BYTES);
    localparam int EXT_W    = XLEN - VA_BITS + 1;

    typedef struct packed {
        walk_state_e      state;
        logic [VPN_W-1:0] vpn;
        access_e          kind;
        logic             sup;
        logic [XLEN-1:0]  base;
        logic [LVL_W-1:0] level;
        logic [XLEN-1:0]  mem_size;
        logic [XLEN-1:0]  pte_addr;
        logic [XLEN-1:0]  wb_data;
        logic [XLEN-1:0]  page_base;
        logic             base_bad;
        logic             done;
        logic             fault;
        logic [XLEN-1:0]  result;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [EXT_W-1:0] va_ext;
    logic             va_canon;
    logic [XLEN-1:0]  idx_addr;
    logic             idx_in_range;
    logic             lf_valid, lf_table, lf_perm_ok, lf_base_ok;
    logic [XLEN-1:0]  lf_next_base, lf_page_base, lf_wb_data;

    assign va_ext   = req_va_hi[XLEN-1:VA_BITS-1];
    assign va_canon = (&va_ext) || !(|va_ext);

    sv39_walk_index #(
        .XLEN(XLEN), .IDX_W(IDX_W), .LEVELS(LEVELS),
        .LVL_W(LVL_W), .PTE_LOG2(PTE_LOG2)
    ) u_index (
        .vpn      (r_q.vpn),
        .level    (r_q.level),
        .base     (r_q.base),
        .mem_size (r_q.mem_size),
        .pte_addr (idx_addr),
        .in_range (idx_in_range)
    );

    sv39_walk_leaf #(
        .XLEN(XLEN), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
        .LEVELS(LEVELS), .LVL_W(LVL_W)
    ) u_leaf (
        .pte       (mem_rsp_rdata),
        .kind      (r_q.kind),
        .sup       (r_q.sup),
        .vpn       (r_q.vpn),
        .level     (r_q.level),
        .mem_size  (r_q.mem_size),
        .valid     (lf_valid),
        .is_table  (lf_table),
        .perm_ok   (lf_perm_ok),
        .next_base (lf_next_base),
        .page_base (lf_page_base),
        .base_ok   (lf_base_ok),
        .wb_data   (lf_wb_data)
    );

    always_comb begin
        r_d           = r_q;
        r_d.done      = 1'b0;
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = idx_addr;
        mem_req_wdata = r_q.wb_data;

        unique case (r_q.state)
            WS_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.vpn      = req_va_hi[PG_SHIFT +: VPN_W];
                    r_d.sup      = req_supervisor;
                    r_d.kind     = req_fetch ? ACC_FETCH :
                                   req_store ? ACC_STORE : ACC_LOAD;
                    r_d.base     = root_base;
                    r_d.level    = LVL_W'(LEVELS - 1);
                    r_d.mem_size = mem_size;
                    if (va_canon) begin
                        r_d.state = WS_RD_REQ;
                    end else begin
                        r_d.done   = 1'b1;
                        r_d.fault  = 1'b1;
                        r_d.result = '0;
                    end
                end
            end
            WS_RD_REQ: begin
                if (!idx_in_range) begin
                    r_d.state  = WS_IDLE;
                    r_d.done   = 1'b1;
                    r_d.fault  = 1'b1;
                    r_d.result = '0;
                end else begin
                    mem_req_valid = 1'b1;
                    if (mem_req_ready) begin
                        r_d.pte_addr = idx_addr;
                        r_d.state    = WS_RD_RSP;
                    end
                end
            end
            WS_RD_RSP: begin
                if (mem_rsp_valid) begin
                    if (!lf_valid || (lf_table && r_q.level == '0) ||
                        (!lf_table && !lf_perm_ok)) begin
                        r_d.state  = WS_IDLE;
                        r_d.done   = 1'b1;
                        r_d.fault  = 1'b1;
                        r_d.result = '0;
                    end else if (lf_table) begin
                        r_d.base  = lf_next_base;
                        r_d.level = r_q.level - 1'b1;
                        r_d.state = WS_RD_REQ;
                    end else begin
                        r_d.wb_data   = lf_wb_data;
                        r_d.page_base = lf_page_base;
                        r_d.base_bad  = !lf_base_ok;
                        r_d.state     = WS_WR_REQ;
                    end
                end
            end
            WS_WR_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = r_q.pte_addr;
                if (mem_req_ready) r_d.state = WS_WR_RSP;
            end
            WS_WR_RSP: begin
                if (mem_rsp_valid) begin
                    r_d.state  = WS_IDLE;
                    r_d.done   = 1'b1;
                    r_d.fault  = r_q.base_bad;
                    r_d.result = r_q.base_bad ? '0 : r_q.page_base;
                end
            end
            default: r_d.state = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done       = r_q.done;
    assign done_fault = r_q.fault;
    assign done_base  = r_q.result;
endmodule

// File: rtl/sv39_walker_chk.sv
module sv39_walker_chk #(
    parameter int XLEN     = 64,
    parameter int EXT_W    = 26,
    parameter int PG_SHIFT = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [EXT_W-1:0] va_ext,
    input logic [XLEN-1:0]  mem_size,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic             mem_req_write,
    input logic [XLEN-1:0]  mem_req_addr,
    input logic [XLEN-1:0]  mem_req_wdata,
    input logic             done,
    input logic             done_fault,
    input logic [XLEN-1:0]  done_base
);
    // R1
    noncanon_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !((&va_ext) || !(|va_ext)) |=> done && done_fault);

    // R2
    entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

    // R3
    read_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_write |-> mem_req_addr < mem_size);

    // R7
    ref_bit_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> mem_req_wdata[5]);

    // R8
    base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !done_fault |-> done_base[PG_SHIFT-1:0] == '0);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata));

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R10
    fault_base_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_fault |-> done_base == '0);
endmodule

bind sv39_walker sv39_walker_chk #(
    .XLEN(XLEN), .EXT_W(XLEN - VA_BITS + 1), .PG_SHIFT(PG_SHIFT)
) u_walker_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .va_ext        (req_va_hi[XLEN-1:VA_BITS-1]),
    .mem_size      (mem_size),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .done          (done),
    .done_fault    (done_fault),
    .done_base     (done_base)
);

// File: tb/test_sv39_walker.sv
`timescale 1ns/1ps
module test_sv39_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:12] req_va_hi = '0;
    logic        req_supervisor = 1'b0, req_store = 1'b0, req_fetch = 1'b0;
    logic [63:0] root_base = '0, mem_size = '0;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;
    logic        done, done_fault;
    logic [63:0] done_base;

    int n_chk = 0, n_fail = 0;

    logic [63:0] pmem [logic [63:0]];
    logic [63:0] obs_rd [$];
    int          obs_wr;
    logic [63:0] obs_wa, obs_wd;

    logic        exp_flt, exp_wr;
    logic [63:0] exp_base, exp_wa, exp_wd;
    logic [63:0] exp_rd [3];
    int          exp_nrd;

    always #2.5 clk = ~clk;

    sv39_walker i_sv39_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va_hi(req_va_hi), .req_supervisor(req_supervisor),
        .req_store(req_store), .req_fetch(req_fetch),
        .root_base(root_base), .mem_size(mem_size),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .done(done), .done_fault(done_fault),
        .done_base(done_base)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Memory responder: random accept delay, random response delay
    initial begin
        int ph = 0;
        int wt = 0;
        logic [63:0] cap_addr = '0;
        logic        cap_wr = 1'b0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (ph == 0) begin
                if (mem_req_valid && ($urandom % 3 != 0)) begin
                    mem_req_ready = 1'b1;
                    cap_addr = mem_req_addr;
                    cap_wr   = mem_req_write;
                    if (cap_wr) begin
                        pmem[cap_addr] = mem_req_wdata;
                        obs_wr++;
                        obs_wa = cap_addr;
                        obs_wd = mem_req_wdata;
                    end else begin
                        obs_rd.push_back(cap_addr);
                    end
                    ph = 1;
                end
            end else if (ph == 1) begin
                mem_req_ready = 1'b0;
                wt = $urandom % 3;
                ph = 2;
            end
            if (ph == 2) begin
                if (wt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = (!cap_wr && pmem.exists(cap_addr)) ? pmem[cap_addr] : 64'h0;
                    ph = 0;
                end else begin
                    wt--;
                end
            end
        end
    end

    function automatic logic [63:0] slot(input logic [63:0] b, input logic [63:0] va, input int l);
        return b + (((va >> (12 + 9*l)) & 64'h1ff) << 3);
    endfunction

    function automatic logic [63:0] tbl(input logic [63:0] pg);
        return (pg << 10) | 64'h1;
    endfunction

    function automatic logic [63:0] leaf(input logic [63:0] ppn, input logic [3:0] t);
        return (ppn << 10) | (64'(t) << 1) | 64'h1;
    endfunction

    // Reference model of the walk, from the requirements
    function automatic void model(input logic [63:0] va, input logic sup, input logic st,
                                  input logic fe, input logic [63:0] root, input logic [63:0] msz);
        logic [63:0] b, a, pte, pg;
        logic [3:0]  t;
        logic        need;
        exp_flt = 1'b1; exp_base = '0; exp_wr = 1'b0; exp_wa = '0; exp_wd = '0; exp_nrd = 0;
        if (va[63:38] != '0 && va[63:38] != '1) return;
        b = root;
        for (int l = 2; l >= 0; l--) begin
            a = slot(b, va, l);
            if (a >= msz) return;
            exp_rd[exp_nrd] = a;
            exp_nrd++;
            pte = pmem.exists(a) ? pmem[a] : 64'h0;
            if (!pte[0]) return;
            t = pte[4:1];
            if (t == 4'd0) begin
                b = (pte >> 10) << 12;
                continue;
            end
            need = fe ? t[2] : (st ? t[1] : t[0]);
            if (!need || (t[3] == sup)) return;
            exp_wr = 1'b1;
            exp_wa = a;
            exp_wd = pte | 64'h20 | ((st && !fe) ? 64'h40 : 64'h0);
            pg = ((pte >> 10) | ((va >> 12) & ((64'd1 << (9*l)) - 64'd1))) << 12;
            if (pg >= msz) return;
            exp_flt = 1'b0;
            exp_base = pg;
            return;
        end
    endfunction

    task automatic run_walk(input logic [63:0] va, input logic sup, input logic st,
                            input logic fe, input string tag);
        int n = 0;
        model(va, sup, st, fe, root_base, mem_size);
        obs_rd.delete();
        obs_wr = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_va_hi = va[63:12];
        req_supervisor = sup; req_store = st; req_fetch = fe;
        @(negedge clk);
        req_valid = 1'b0;
        if (!done) chk(req_ready == 1'b0, "R10", "ready while busy", 64'(req_ready), 64'd0);
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            chk(1'b0, tag, "walk timeout", 64'(n), 64'd0);
            return;
        end
        chk(done_fault == exp_flt, tag, "fault", 64'(done_fault), 64'(exp_flt));
        chk(done_base == exp_base, tag, "page base", done_base, exp_base);
        chk(obs_rd.size() == exp_nrd, "R2", "read count", 64'(obs_rd.size()), 64'(exp_nrd));
        if (obs_rd.size() == exp_nrd)
            for (int i = 0; i < exp_nrd; i++)
                chk(obs_rd[i] == exp_rd[i], "R2", "entry address", obs_rd[i], exp_rd[i]);
        chk(obs_wr == int'(exp_wr), "R7", "write count", 64'(obs_wr), 64'(exp_wr));
        if (exp_wr && obs_wr == 1) begin
            chk(obs_wa == exp_wa, "R7", "write address", obs_wa, exp_wa);
            chk(obs_wd == exp_wd, "R7", "write data", obs_wd, exp_wd);
        end
        @(negedge clk);
        chk(done == 1'b0, "R10", "done one cycle", 64'(done), 64'd0);
    endtask

    task automatic set_env(input logic [63:0] root, input logic [63:0] msz);
        pmem.delete();
        root_base = root;
        mem_size = msz;
    endtask

    task automatic random_walk();
        logic [63:0] msz, npg, root, va, b, a, pg;
        logic        sup, st, fe;
        logic [3:0]  t;
        int          r;
        msz  = ($urandom % 2) ? 64'h0400_0000 : 64'h1_0000_0000;
        npg  = msz >> 12;
        root = (64'($urandom) % npg) << 12;
        if ($urandom % 10 == 0) root = msz - 64'h800;
        va = {$urandom, $urandom} & ((64'd1 << 39) - 1);
        if (va[38]) va = va | ~((64'd1 << 39) - 1);
        if ($urandom % 16 == 0) va = va ^ (64'd1 << (39 + $urandom % 25));
        sup = 1'($urandom); st = 1'($urandom); fe = 1'($urandom);
        set_env(root, msz);
        b = root;
        for (int l = 2; l >= 0; l--) begin
            a = slot(b, va, l);
            r = $urandom % 10;
            if (r < 1) begin
                pmem[a] = {$urandom, $urandom} & ~64'h1;
                break;
            end else if (r < 5) begin
                pg = 64'($urandom) % npg;
                if ($urandom % 8 == 0) pg = npg + 64'($urandom % 4);
                pmem[a] = tbl(pg) | (64'($urandom % 32) << 5);
                b = pg << 12;
            end else begin
                if ($urandom % 2) t = (sup ? 4'd0 : 4'd8) | (fe ? 4'd4 : st ? 4'd2 : 4'd1) | 4'($urandom % 8);
                else t = 4'(1 + $urandom % 15);
                pg = 64'($urandom) % npg;
                if ($urandom % 4 == 0) pg = 64'($urandom % (1 << 22));
                pmem[a] = leaf(pg, t);
                break;
            end
        end
        run_walk(va, sup, st, fe, "R8");
    endtask

    initial begin
        logic [63:0] va;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "reset ready", 64'(req_ready), 64'd1);
        chk(done == 1'b0, "R10", "reset done", 64'(done), 64'd0);
        chk(mem_req_valid == 1'b0, "R10", "reset mem valid", 64'(mem_req_valid), 64'd0);

        // R1: non-canonical address
        set_env(64'h1_0000, 64'h0400_0000);
        run_walk(64'h0000_0040_0000_0000, 1'b1, 1'b0, 1'b0, "R1");
        run_walk(64'hFFFF_FFBF_FFFF_F000, 1'b0, 1'b0, 1'b0, "R1");

        // R2 / R8: 4 KiB load through two tables
        va = 64'h0000_0000_4060_3ABC;
        set_env(64'h1_0000, 64'h0400_0000);
        pmem[slot(64'h1_0000, va, 2)] = tbl(64'h20);
        pmem[slot(64'h2_0000, va, 1)] = tbl(64'h21);
        pmem[slot(64'h2_1000, va, 0)] = leaf(64'h1234, 4'd1);
        run_walk(va, 1'b1, 1'b0, 1'b0, "R8");
        chk(done_base == 64'h0123_4000 || exp_base == 64'h0123_4000, "R8", "4K base", exp_base, 64'h0123_4000);

        // R7 / R8: 2 MiB store sets dirty
        va = 64'h0000_0001_2345_6000;
        set_env(64'h1_0000, 64'h0400_0000);
        pmem[slot(64'h1_0000, va, 2)] = tbl(64'h30);
        pmem[slot(64'h3_0000, va, 1)] = leaf(64'h600, 4'd3);
        run_walk(va, 1'b1, 1'b1, 1'b0, "R7");

        // R8: 1 GiB user fetch
        va = 64'hFFFF_FFC0_1234_5000;
        set_env(64'h1_0000, 64'h1_0000_0000);
        pmem[slot(64'h1_0000, va, 2)] = leaf(64'h4_0000, 4'd12);
        run_walk(va, 1'b0, 1'b0, 1'b1, "R8");

        // R6: permission failures and fetch priority
        va = 64'h0000_0000_0000_5000;
        set_env(64'h1_0000, 64'h0400_0000);
        pmem[slot(64'h1_0000, va, 2)] = leaf(64'h0, 4'd1);
        run_walk(va, 1'b1, 1'b1, 1'b0, "R6");
        pmem[slot(64'h1_0000, va, 2)] = leaf(64'h0, 4'd9);
        run_walk(va, 1'b1, 1'b0, 1'b0, "R6");
        pmem[slot(64'h1_0000, va, 2)] = leaf(64'h0, 4'd3);
        run_walk(va, 1'b1, 1'b1, 1'b1, "R6");
        pmem[slot(64'h1_0000, va, 2)] = leaf(64'h0, 4'd4);
        run_walk(va, 1'b1, 1'b1, 1'b1, "R6");

        // R4: invalid entry
        set_env(64'h1_0000, 64'h0400_0000);
        pmem[slot(64'h1_0000, va, 2)] = 64'hFFFF_FFFF_FFFF_FFFE;
        run_walk(va, 1'b1, 1'b0, 1'b0, "R4");

        // R5: table at the last level
        set_env(64'h1_0000, 64'h0400_0000);
        pmem[slot(64'h1_0000, va, 2)] = tbl(64'h40);
        pmem[slot(64'h4_0000, va, 1)] = tbl(64'h41);
        pmem[slot(64'h4_1000, va, 0)] = tbl(64'h42);
        run_walk(va, 1'b1, 1'b0, 1'b0, "R5");

        // R3: entry address out of range, at root and after a table
        set_env(64'h0400_0000, 64'h0400_0000);
        run_walk(va, 1'b1, 1'b0, 1'b0, "R3");
        set_env(64'h1_0000, 64'h0400_0000);
        pmem[slot(64'h1_0000, va, 2)] = tbl(64'h4000);
        run_walk(va, 1'b1, 1'b0, 1'b0, "R3");

        // R9: final base out of range after write-back
        va = 64'h0000_0000_0800_0000;
        set_env(64'h1_0000, 64'h0400_0000);
        pmem[slot(64'h1_0000, va, 2)] = leaf(64'h0, 4'd1);
        run_walk(va, 1'b1, 1'b0, 1'b0, "R9");

        for (int i = 0; i < 400; i++) random_walk();

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule